// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block is the transfer engine inside a four-channel DMA controller. On every clock it looks at which channels are unmasked and have a pending request. It picks one of them and performs one transfer step for that channel. The step advances the channel's byte position and raises a one-cycle acknowledge for the channel. The block drives a wide memory address for the step. It also signals terminal count when the channel's programmed length has been moved.

The block serves a byte controller (`WSHIFT = 0`) or a word controller (`WSHIFT = 1`). On the word controller each step moves two bytes, the length doubles, and the reported channel number is offset by the channel count. The surrounding register file owns the mask, request, mode, count and address registers and feeds them in. It also pulses `reprog_i` when software rewrites a channel, which restarts that channel's progress. All outputs are registered, so they describe the step chosen in the previous cycle.

Top module: `dma_service_seq`

## Requirements
- R1: A channel is serviced only in a cycle where its mask bit is 0, its request bit is 1, it is not stopped and `reprog_i` for it is 0.
- R2: When several channels are serviceable, the lowest-numbered one is serviced. `dack_o` is one-hot or zero, and `xfer_valid_o` is 1 exactly when one bit of `dack_o` is 1.
- R3: Each service step advances the channel position by `1 << WSHIFT` bytes. Position starts at 0.
- R4: `mem_addr_o` is {high page[6:0], page[7:0], offset address[15:0]} of the serviced channel (high page in the top 7 bits).
- R5: With the channel's direction bit at 0, the offset address is current address + position, modulo 2^16.
- R6: With the direction bit at 1, the offset address is current address − position, modulo 2^16 (wrapping below zero).
- R7: `tc_o[c]` pulses for one cycle, together with `dack_o[c]`, on the step after which the position equals (base count + 1) << WSHIFT.
- R8: On terminal count with the channel's auto-init bit at 1, the position returns to 0 and the channel stays serviceable.
- R9: On terminal count with auto-init at 0, the channel is stopped and receives no further service until reprogrammed.
- R10: A `reprog_i[c]` pulse clears the position and the stopped state of channel c; the channel is not serviced in that cycle.
- R11: `chan_id_o` is the serviced local channel number plus 4 when WSHIFT = 1 (plus 0 when WSHIFT = 0).
- R12: While and after synchronous reset, with no step taken, `xfer_valid_o`, `dack_o` and `tc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_i | input | NCH | Per-channel mask bits (1 = masked) |
| req_i | input | NCH | Per-channel request status bits |
| dir_down_i | input | NCH | Per-channel direction bit (1 = downward) |
| auto_init_i | input | NCH | Per-channel auto-initialize bit |
| reprog_i | input | NCH | Per-channel reprogram pulse |
| base_cnt_i | input | NCH*CNT_W | Base counts, channel 0 in the low slice |
| cur_addr_i | input | NCH*ADDR_W | Current addresses, channel 0 in the low slice |
| page_i | input | NCH*PG_W | Page registers |
| hpage_i | input | NCH*HP_W | High-page registers |
| xfer_valid_o | output | 1 | A transfer step is presented this cycle |
| dack_o | output | NCH | One-cycle acknowledge of the serviced channel |
| chan_id_o | output | IDX_W+1 | Reported channel number |
| mem_addr_o | output | HP_W+PG_W+ADDR_W | Physical address of the step |
| tc_o | output | NCH | Terminal-count pulse per channel |

## Verification
The bench runs a word-controller instance. It tries a lone upward channel that runs to terminal count and then sits stopped. This separates a correct length and stop from an off-by-one or a channel that keeps running. It then tries simultaneous requests on two channels, which exposes the priority order. An auto-initialized length-of-one channel gives terminal count on every step and tells reload apart from stop. A downward channel starting near zero checks subtraction and the 16-bit wrap. Masked-but-requesting and unmasked-but-idle patterns, plus a reprogram pulse, show that gating and restart act on the ports.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   elig,
  output logic [NCH-1:0]   grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest eligible channel is written last.
  always_comb begin
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        any      = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_chan_pos.sv
module dma_chan_pos #(
  parameter int CNT_W  = 16,
  parameter int WSHIFT = 0,
  localparam int POS_W = CNT_W + 1 + WSHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  input  logic             reprog,
  input  logic             auto_init,
  input  logic [CNT_W-1:0] base_cnt,
  output logic [POS_W-1:0] pos,
  output logic             stopped,
  output logic             hit
);
  localparam logic [POS_W-1:0] STEP = POS_W'(1) << WSHIFT;

  logic [POS_W-1:0] len;
  logic [POS_W-1:0] pos_nxt;

  assign len     = (POS_W'(base_cnt) + POS_W'(1)) << WSHIFT;
  assign pos_nxt = pos + STEP;
  assign hit     = grant && (pos_nxt == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      stopped <= 1'b0;
    end else if (reprog) begin
      pos     <= '0;
      stopped <= 1'b0;
    end else if (grant) begin
      if (pos_nxt == len) begin
        if (auto_init) begin
          pos <= '0;
        end else begin
          pos     <= pos_nxt;
          stopped <= 1'b1;
        end
      end else begin
        pos <= pos_nxt;
      end
    end
  end

  // R9: a stopped channel is never granted unless it is being reprogrammed
  p_stopped_no_grant_r9: assert property (@(posedge clk) disable iff (rst)
    (stopped && !reprog) |-> !grant);

  // R3: a non-terminal step moves the position by one unit
  p_step_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (grant && !reprog && !hit) |=> (pos == $past(pos) + STEP));

  // R8: terminal count with auto-init reloads the position
  p_auto_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (grant && !reprog && hit && auto_init) |=> (pos == '0 && !stopped));

  // R10: reprogram clears progress
  p_reprog_clear_r10: assert property (@(posedge clk) disable iff (rst)
    reprog |=> (pos == '0 && !stopped));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PG_W   = 8,
  parameter int HP_W   = 7,
  parameter int POS_W  = 17,
  localparam int MA_W  = HP_W + PG_W + ADDR_W
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [POS_W-1:0]  pos,
  input  step_dir_e         dir,
  input  logic [PG_W-1:0]   page,
  input  logic [HP_W-1:0]   hpage,
  output logic [MA_W-1:0]   addr
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] low;

  assign off = ADDR_W'(pos);

  always_comb begin
    if (dir == DIR_DOWN) low = cur_addr - off;
    else                 low = cur_addr + off;
  end

  assign addr = {hpage, page, low};
endmodule

// File: rtl/dma_service_seq.sv
module dma_service_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WSHIFT = 0,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16,
  parameter int PG_W   = 8,
  parameter int HP_W   = 7,
  localparam int IDX_W = $clog2(NCH),
  localparam int ID_W  = IDX_W + 1,
  localparam int POS_W = CNT_W + 1 + WSHIFT,
  localparam int MA_W  = HP_W + PG_W + ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        mask_i,
  input  logic [NCH-1:0]        req_i,
  input  logic [NCH-1:0]        dir_down_i,
  input  logic [NCH-1:0]        auto_init_i,
  input  logic [NCH-1:0]        reprog_i,
  input  logic [NCH*CNT_W-1:0]  base_cnt_i,
  input  logic [NCH*ADDR_W-1:0] cur_addr_i,
  input  logic [NCH*PG_W-1:0]   page_i,
  input  logic [NCH*HP_W-1:0]   hpage_i,
  output logic                  xfer_valid_o,
  output logic [NCH-1:0]        dack_o,
  output logic [ID_W-1:0]       chan_id_o,
  output logic [MA_W-1:0]       mem_addr_o,
  output logic [NCH-1:0]        tc_o
);
  localparam logic [ID_W-1:0] ID_OFF = (WSHIFT != 0) ? ID_W'(NCH) : '0;

  logic [NCH-1:0]    elig, grant, stopped, hit;
  logic              any;
  logic [IDX_W-1:0]  idx;
  logic [POS_W-1:0]  pos    [NCH];
  logic [ADDR_W-1:0] cur    [NCH];
  logic [PG_W-1:0]   pg     [NCH];
  logic [HP_W-1:0]   hp     [NCH];
  logic [MA_W-1:0]   addr_c;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign cur[c]  = cur_addr_i[c*ADDR_W +: ADDR_W];
    assign pg[c]   = page_i[c*PG_W +: PG_W];
    assign hp[c]   = hpage_i[c*HP_W +: HP_W];
    assign elig[c] = !mask_i[c] && req_i[c] && !stopped[c] && !reprog_i[c];

    dma_chan_pos #(.CNT_W(CNT_W), .WSHIFT(WSHIFT)) u_pos (
      .clk      (clk),
      .rst      (rst),
      .grant    (grant[c]),
      .reprog   (reprog_i[c]),
      .auto_init(auto_init_i[c]),
      .base_cnt (base_cnt_i[c*CNT_W +: CNT_W]),
      .pos      (pos[c]),
      .stopped  (stopped[c]),
      .hit      (hit[c])
    );

    // R1: acknowledge only for a channel that was unmasked and requesting
    p_serviceable_r1: assert property (@(posedge clk) disable iff (rst)
      dack_o[c] |-> $past(!mask_i[c] && req_i[c]));

    // R7: terminal count rides on the acknowledge of the same channel
    p_tc_with_dack_r7: assert property (@(posedge clk) disable iff (rst)
      tc_o[c] |-> dack_o[c]);
  end

  dma_prio_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .elig (elig),
    .grant(grant),
    .any  (any),
    .idx  (idx)
  );

  dma_addr_gen #(
    .ADDR_W(ADDR_W), .PG_W(PG_W), .HP_W(HP_W), .POS_W(POS_W)
  ) u_addr (
    .cur_addr(cur[idx]),
    .pos     (pos[idx]),
    .dir     (step_dir_e'(dir_down_i[idx])),
    .page    (pg[idx]),
    .hpage   (hp[idx]),
    .addr    (addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_valid_o <= 1'b0;
      dack_o       <= '0;
      chan_id_o    <= '0;
      mem_addr_o   <= '0;
      tc_o         <= '0;
    end else begin
      xfer_valid_o <= any;
      dack_o       <= grant;
      tc_o         <= hit;
      if (any) begin
        chan_id_o  <= ID_W'(idx) + ID_OFF;
        mem_addr_o <= addr_c;
      end
    end
  end

  // R2: at most one acknowledge, and valid tracks it
  p_dack_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack_o));
  p_valid_matches_r2: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o == ($countones(dack_o) == 1));

  // R11: reported number points at the acknowledged channel
  p_id_matches_r11: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o |-> (dack_o == (NCH'(1) << (chan_id_o - ID_OFF))));

  // R12: nothing is acknowledged right after reset
  p_reset_quiet_r12: assert property (@(posedge clk)
    $past(rst) |-> (dack_o == '0 && tc_o == '0 && !xfer_valid_o));
endmodule

// File: tb/tb_dma_service_seq.sv
module tb_dma_service_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  typedef struct {
    bit          v;
    logic [3:0]  dk;
    logic [2:0]  id;
    logic [30:0] a;
    logic [3:0]  tc;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] msk = 4'hF, rq = 4'h0, dn = 4'h0, ai = 4'h0, rp = 4'h0;
  logic [15:0] bc [4];
  logic [15:0] cur [4];
  logic [7:0]  pg [4];
  logic [6:0]  hp [4];
  logic [63:0] bc_p, cur_p;
  logic [31:0] pg_p;
  logic [27:0] hp_p;

  logic        xv;
  logic [3:0]  dack, tc;
  logic [2:0]  cid;
  logic [30:0] maddr;

  int checks = 0;
  int errors = 0;
  int mpos [4];
  bit mstop [4];
  exp_t q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      bc_p[c*16 +: 16]  = bc[c];
      cur_p[c*16 +: 16] = cur[c];
      pg_p[c*8 +: 8]    = pg[c];
      hp_p[c*7 +: 7]    = hp[c];
    end
  end

  dma_service_seq #(.NCH(NCH), .WSHIFT(1)) dut (
    .clk(clk), .rst(rst),
    .mask_i(msk), .req_i(rq), .dir_down_i(dn), .auto_init_i(ai),
    .reprog_i(rp), .base_cnt_i(bc_p), .cur_addr_i(cur_p),
    .page_i(pg_p), .hpage_i(hp_p),
    .xfer_valid_o(xv), .dack_o(dack), .chan_id_o(cid),
    .mem_addr_o(maddr), .tc_o(tc)
  );

  // Driver: compute the expected step from the requirements, push, advance.
  task automatic step(input string tag);
    exp_t e;
    int s;
    int np;
    int ln;
    logic [15:0] off, a16;
    s = -1;
    for (int c = 3; c >= 0; c--)
      if (!msk[c] && rq[c] && !mstop[c] && !rp[c]) s = c;
    for (int c = 0; c < 4; c++)
      if (rp[c]) begin mpos[c] = 0; mstop[c] = 0; end
    e.v = 0; e.dk = '0; e.id = '0; e.a = '0; e.tc = '0; e.tag = tag;
    if (s >= 0) begin
      e.v = 1;
      e.dk = 4'(1) << s;
      e.id = 3'(s + 4);
      off = 16'(mpos[s]);
      a16 = dn[s] ? cur[s] - off : cur[s] + off;
      e.a = {hp[s], pg[s], a16};
      np = mpos[s] + 2;
      ln = (int'(bc[s]) + 1) * 2;
      if (np == ln) begin
        e.tc[s] = 1'b1;
        if (ai[s]) mpos[s] = 0;
        else begin mpos[s] = np; mstop[s] = 1; end
      end else begin
        mpos[s] = np;
      end
    end
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare registered outputs just after the edge that produced them.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (xv !== e.v || dack !== e.dk || tc !== e.tc ||
          (e.v && (cid !== e.id || maddr !== e.a))) begin
        errors++;
        $display("FAIL %s: got v=%0b dack=%b id=%0d addr=%h tc=%b, exp v=%0b dack=%b id=%0d addr=%h tc=%b",
                 e.tag, xv, dack, cid, maddr, tc, e.v, e.dk, e.id, e.a, e.tc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      mpos[c] = 0; mstop[c] = 0;
      bc[c] = '0; cur[c] = '0; pg[c] = '0; hp[c] = '0;
    end
    bc[1] = 16'd2; cur[1] = 16'h1000; pg[1] = 8'hA5; hp[1] = 7'h55;
    bc[2] = 16'd0; cur[2] = 16'h8000; pg[2] = 8'h11; hp[2] = 7'h01;
    bc[3] = 16'd2; cur[3] = 16'h0002; pg[3] = 8'h3C; hp[3] = 7'h7F;

    // R12: an eligible channel during reset produces nothing
    msk = 4'hE; rq = 4'h1;
    repeat (3) @(negedge clk);
    checks++;
    if (xv !== 1'b0 || dack !== 4'h0 || tc !== 4'h0) begin
      errors++;
      $display("FAIL R12: got v=%0b dack=%b tc=%b, exp 0 0 0", xv, dack, tc);
    end
    msk = 4'hF; rq = 4'h0;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (xv !== 1'b0 || dack !== 4'h0 || tc !== 4'h0) begin
      errors++;
      $display("FAIL R12: got v=%0b dack=%b tc=%b, exp 0 0 0", xv, dack, tc);
    end

    // R1: masked but requesting, then unmasked but not requesting
    msk = 4'hF; rq = 4'h1;
    step("R1 masked"); step("R1 masked");
    msk = 4'hE; rq = 4'h0;
    step("R1 no request");

    // R3 R4 R5 R7 R9 R11: channel 1 upward, three word steps, then stopped
    msk = 4'hD; rq = 4'h2;
    step("R3 R4 R5 R11 ch1 step0");
    step("R3 R5 ch1 step1");
    step("R7 ch1 terminal");
    step("R9 ch1 stopped");
    step("R9 ch1 stopped");

    // R10: reprogram pulse restarts channel 1 from position 0
    rp = 4'h2;
    step("R10 reprog cycle");
    rp = 4'h0;
    step("R10 ch1 restarted");
    rq = 4'h0;
    step("R1 request dropped");

    // R2 R8: channels 2 (auto-init, length 2 bytes) and 3 both eligible
    msk = 4'h3; rq = 4'hC; ai = 4'h4; dn = 4'h8;
    step("R2 R8 ch2 wins");
    step("R2 R8 ch2 wins");
    step("R2 R8 ch2 wins");

    // R6: channel 3 alone, downward from 0x0002, wraps below zero
    msk = 4'h7;
    step("R6 ch3 down 0");
    step("R6 ch3 down 1");
    step("R6 R7 ch3 wrap terminal");
    step("R9 ch3 stopped");

    msk = 4'hF; rq = 4'h0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule